// File: doc/BRIEF.md
# Parallel Camera Pixel Capture

This block receives an 8-bit parallel image-sensor stream, one byte per rising edge of the sensor pixel clock. A line-valid strobe and a separate frame-sync strobe frame the stream. The block gathers each group of four bytes into one 32-bit word that holds two pixels of YUV 4:2:2 data. It can mirror every line left to right. It delivers the words into a faster system-clock domain through an asynchronous FIFO, and tags each word with start-of-frame and end-of-line flags.

Software selects the active level of each strobe, the byte order the sensor sends, the line width in pixels, mirroring, and a capture mode. A capture decision is taken only when a frame begins. Stopping capture, or switching to single-shot, never cuts a frame short. Frame and line counters and two sticky error flags are kept in the pixel-clock domain. The configuration inputs are treated as static while a frame is in flight. The mode input is synchronised into the pixel domain.

Top module: `pixcap_top`

## Requirements
- R1: `cfg_href_low` and `cfg_vsync_low` pick the active level of each strobe: 0 means active high and 1 means active low. An inverted stream with the matching bits set gives exactly the same output words.
- R2: `cfg_order` names the byte sequence within each 4-byte group: 0 = Y0 Cb Y1 Cr, 1 = Y0 Cr Y1 Cb, 2 = Cb Y0 Cr Y1, 3 = Cr Y0 Cb Y1. The output word always carries Y0 in bits 31:24, Cb in 23:16, Y1 in 15:8 and Cr in 7:0.
- R3: With `cfg_mirror` set, the words of a line are delivered in reverse order and Y0 and Y1 are swapped inside each word. Cb and Cr stay in place.
- R4: Words of a line leave in line order. `sys_sof` marks the first word of each captured frame and `sys_eol` marks the last word of each line.
- R5: `cap_mode` 0 and 3 stop capture, 1 captures every frame and 2 is single-shot. The mode is applied only at the frame-sync active edge, so a change made mid-frame leaves the current frame whole.
- R6: In single-shot mode exactly one frame is captured each time the mode enters single-shot.
- R7: A line yields min(floor(bytes/4), `cfg_width`/2) words. Bytes past 2*`cfg_width`, and a trailing partial group, are discarded.
- R8: `line_err` is set, and stays set until reset, when a captured line has an odd byte count or fewer than 2*`cfg_width` bytes.
- R9: `frame_cnt` increments at each captured frame start. `line_cnt` counts the lines of the latest captured frame and restarts from zero at each captured frame start.
- R10: A word that meets a full FIFO is lost, together with every later word of that frame, and `ovf_err` is set and stays set. The next frame is delivered normally.
- R11: After reset there is no output word, both counters are zero and both error flags are clear.
- R12: Words cross into the system domain in order and without loss when `sys_ready` is throttled and the FIFO never fills. A presented word is held stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | sensor pixel clock |
| prst_n | input | 1 | active-low reset, pixel domain |
| cam_d | input | 8 | pixel byte |
| cam_href | input | 1 | line-valid strobe (raw level) |
| cam_vsync | input | 1 | frame-sync strobe (raw level) |
| cfg_href_low | input | 1 | 1: line strobe active low |
| cfg_vsync_low | input | 1 | 1: frame strobe active low |
| cfg_order | input | 2 | incoming byte order code |
| cfg_mirror | input | 1 | mirror each line |
| cfg_width | input | 14 | line width in pixels (even) |
| cap_mode | input | 2 | capture mode (synchronised) |
| sys_clk | input | 1 | system clock, faster than pclk |
| srst_n | input | 1 | active-low reset, system domain |
| sys_ready | input | 1 | consumer takes the presented word |
| sys_valid | output | 1 | a word is presented |
| sys_data | output | 32 | two-pixel word Y0 Cb Y1 Cr |
| sys_sof | output | 1 | first word of a frame |
| sys_eol | output | 1 | last word of a line |
| frame_cnt | output | 16 | captured frames (pixel domain) |
| line_cnt | output | 14 | lines in the latest captured frame |
| line_err | output | 1 | sticky line-length error |
| ovf_err | output | 1 | sticky FIFO overflow |

## Verification
The bench runs every byte order and both strobe polarities. If the design decoded a byte from the wrong lane, the chroma or luma values would move to the wrong place in the word. If it sampled the wrong strobe level, it would capture blanking bytes or no bytes at all. Mirrored lines are checked at the full buffer depth. A design that forgot to swap Y0 and Y1, or that reversed one word too many, would show a wrong word at the line ends. The bench also sends lines that are long, short, or have an odd byte count, to catch a wrong word count or a missed error flag. Mode changes during a frame and repeated single-shot frames expose a design that gates capture on the wrong edge. A run with the consumer stalled shows whether the block drops the rest of the frame after an overflow and then recovers on the next frame.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

  typedef enum logic [1:0] {
    ORD_Y0CB = 2'd0,
    ORD_Y0CR = 2'd1,
    ORD_CBY0 = 2'd2,
    ORD_CRY0 = 2'd3
  } byte_order_e;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_OFF2 = 2'd3
  } cap_mode_e;

  // Assemble four stream bytes into {Y0, Cb, Y1, Cr}
  function automatic logic [31:0] pack_pair(input logic [7:0] b0, input logic [7:0] b1,
                                            input logic [7:0] b2, input logic [7:0] b3,
                                            input byte_order_e ord);
    case (ord)
      ORD_Y0CB: pack_pair = {b0, b1, b2, b3};
      ORD_Y0CR: pack_pair = {b0, b3, b2, b1};
      ORD_CBY0: pack_pair = {b1, b0, b3, b2};
      default:  pack_pair = {b1, b2, b3, b0};
    endcase
  endfunction

  // Swap the two lumas; chroma is shared by the pair
  function automatic logic [31:0] mirror_pair(input logic [31:0] w);
    mirror_pair = {w[15:8], w[23:16], w[31:24], w[7:0]};
  endfunction

endpackage

// File: rtl/pixcap_front.sv
module pixcap_front
  import pixcap_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int FCNT_W = 16
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic [7:0]        cam_d,
  input  logic              cam_href,
  input  logic              cam_vsync,
  input  logic              cfg_href_low,
  input  logic              cfg_vsync_low,
  input  logic [1:0]        cfg_order,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [1:0]        cap_mode,
  output logic              wr_en,
  output logic [31:0]       wr_data,
  output logic              line_end,
  output logic              line_sof,
  output logic              frame_start,
  output logic [FCNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0]  line_cnt,
  output logic              line_err
);
  localparam int BC_W = CNT_W + 2;

  logic [7:0]      d_q, b0, b1, b2;
  logic            hs_q, hs_d, vs_q, vs_d;
  logic [1:0]      mode_m;
  cap_mode_e       mode_s;
  logic            capturing, armed, sof_pend;
  logic [BC_W-1:0] bcnt;

  // Named events
  logic            take, byte_ok, short_line;
  logic [CNT_W-1:0] half;

  assign frame_start = vs_q & ~vs_d;
  assign take        = frame_start &&
                       ((mode_s == MODE_RUN) || (mode_s == MODE_ONCE && armed));
  assign byte_ok     = capturing & hs_q;
  assign line_end    = capturing & hs_d & ~hs_q;
  assign half        = cfg_width >> 1;
  assign wr_en       = byte_ok && (bcnt[1:0] == 2'd3) && (bcnt[BC_W-1:2] < half);
  assign wr_data     = pack_pair(b0, b1, b2, d_q, byte_order_e'(cfg_order));
  assign short_line  = bcnt < {1'b0, cfg_width, 1'b0};
  assign line_sof    = sof_pend;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0; b0 <= '0; b1 <= '0; b2 <= '0;
      hs_q <= 1'b0; hs_d <= 1'b0; vs_q <= 1'b0; vs_d <= 1'b0;
      mode_m <= '0; mode_s <= MODE_OFF;
      capturing <= 1'b0; armed <= 1'b1; sof_pend <= 1'b0;
      bcnt <= '0; frame_cnt <= '0; line_cnt <= '0; line_err <= 1'b0;
    end else begin
      d_q    <= cam_d;
      hs_q   <= cam_href ^ cfg_href_low;
      vs_q   <= cam_vsync ^ cfg_vsync_low;
      hs_d   <= hs_q;
      vs_d   <= vs_q;
      mode_m <= cap_mode;
      mode_s <= cap_mode_e'(mode_m);
      if (mode_s != MODE_ONCE) armed <= 1'b1;
      if (frame_start) begin
        capturing <= take;
        bcnt      <= '0;
        if (take) begin
          frame_cnt <= frame_cnt + 1'b1;
          line_cnt  <= '0;
          sof_pend  <= 1'b1;
          if (mode_s == MODE_ONCE) armed <= 1'b0;
        end
      end else if (line_end) begin
        bcnt     <= '0;
        line_cnt <= line_cnt + 1'b1;
        if (bcnt[0] || short_line) line_err <= 1'b1;
        if ((|bcnt[BC_W-1:2]) && (half != '0)) sof_pend <= 1'b0;
      end else if (byte_ok) begin
        case (bcnt[1:0])
          2'd0:    b0 <= d_q;
          2'd1:    b1 <= d_q;
          2'd2:    b2 <= d_q;
          default: ;
        endcase
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  // R9
  line_cnt_step_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (line_cnt != $past(line_cnt)) |-> (line_cnt == $past(line_cnt) + 1'b1 || line_cnt == '0));
  // R8
  line_err_sticky_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    line_err |=> line_err);
  // R6
  single_once_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (frame_start && mode_s == MODE_ONCE && !armed) |=> !capturing);

endmodule

// File: rtl/pixcap_linebuf.sv
module pixcap_linebuf
  import pixcap_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [31:0]                 wr_data,
  input  logic                        line_end,
  input  logic                        line_sof,
  input  logic                        mirror,
  input  logic                        frame_start,
  input  logic                        fifo_full,
  output logic                        push,
  output logic [33:0]                 push_data,
  output logic                        ovf,
  output logic [$clog2(MAX_W/2):0]    fill
);
  localparam int DEPTH = MAX_W / 2;
  localparam int AW    = $clog2(DEPTH);

  logic [31:0]  mem [2*DEPTH];
  logic         wbank, rbank, rd_act, rmir, rsof;
  logic [AW:0]  waddr, rn, ridx;
  logic [AW-1:0] rd_addr;
  logic         ov, ov_sof, ov_eol, drop;
  logic [31:0]  ov_data;
  logic         last_rd;

  assign rd_addr   = rmir ? AW'(rn - 1'b1 - ridx) : AW'(ridx);
  assign last_rd   = (ridx == rn - 1'b1);
  assign push      = ov && !drop && !fifo_full;
  assign push_data = {ov_sof, ov_eol, ov_data};
  assign fill      = waddr;

  always_ff @(posedge clk) begin
    if (wr_en && waddr < (AW+1)'(DEPTH)) mem[{wbank, waddr[AW-1:0]}] <= wr_data;
    ov_data <= rmir ? mirror_pair(mem[{rbank, rd_addr}]) : mem[{rbank, rd_addr}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank <= 1'b0; rbank <= 1'b0; waddr <= '0; rn <= '0; ridx <= '0;
      rd_act <= 1'b0; rmir <= 1'b0; rsof <= 1'b0;
      ov <= 1'b0; ov_sof <= 1'b0; ov_eol <= 1'b0; drop <= 1'b0; ovf <= 1'b0;
    end else begin
      if (line_end) begin
        if (waddr != '0) begin
          rd_act <= 1'b1;
          rbank  <= wbank;
          rn     <= waddr;
          ridx   <= '0;
          rsof   <= line_sof;
          rmir   <= mirror;
          wbank  <= ~wbank;
        end
        waddr <= '0;
      end else if (wr_en && waddr < (AW+1)'(DEPTH)) begin
        waddr <= waddr + 1'b1;
      end
      ov <= rd_act;
      if (rd_act) begin
        ov_sof <= rsof && (ridx == '0);
        ov_eol <= last_rd;
        ridx   <= ridx + 1'b1;
        if (last_rd) rd_act <= 1'b0;
      end
      if (frame_start) drop <= 1'b0;
      else if (ov && !drop && fifo_full) begin
        drop <= 1'b1;
        ovf  <= 1'b1;
      end
    end
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);

endmodule

// File: rtl/pixcap_afifo.sv
module pixcap_afifo #(
  parameter int DW = 34,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    to_gray = b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgry, rbin, rgry, rq1, rq2, wq1, wq2;
  logic          do_push, do_pop;

  assign full    = (wgry == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign empty   = (rgry == wq2);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) if (do_push) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgry <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgry;
      rq2 <= rq1;
      if (do_push) begin
        wbin <= wbin + 1'b1;
        wgry <= to_gray(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgry <= '0; wq1 <= '0; wq2 <= '0;
    end else begin
      wq1 <= wgry;
      wq2 <= wq1;
      if (do_pop) begin
        rbin <= rbin + 1'b1;
        rgry <= to_gray(rbin + 1'b1);
      end
    end
  end

  // R10
  full_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (push && full) |=> $stable(wbin));
  // R12
  word_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!empty && !pop) |=> (!empty && $stable(rdata)));

endmodule

// File: rtl/pixcap_top.sv
module pixcap_top #(
  parameter int CNT_W   = 14,
  parameter int FCNT_W  = 16,
  parameter int MAX_W   = 64,
  parameter int FIFO_AW = 4
) (
  input  logic              pclk,
  input  logic              prst_n,
  input  logic [7:0]        cam_d,
  input  logic              cam_href,
  input  logic              cam_vsync,
  input  logic              cfg_href_low,
  input  logic              cfg_vsync_low,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_mirror,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [1:0]        cap_mode,
  input  logic              sys_clk,
  input  logic              srst_n,
  input  logic              sys_ready,
  output logic              sys_valid,
  output logic [31:0]       sys_data,
  output logic              sys_sof,
  output logic              sys_eol,
  output logic [FCNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0]  line_cnt,
  output logic              line_err,
  output logic              ovf_err
);
  localparam int FILL_W = $clog2(MAX_W/2) + 1;

  logic              wr_en, line_end, line_sof, frame_start;
  logic [31:0]       wr_data;
  logic              fifo_full, fifo_empty, push;
  logic [33:0]       push_data, pop_data;
  logic [FILL_W-1:0] lb_fill;

  pixcap_front #(.CNT_W(CNT_W), .FCNT_W(FCNT_W)) front_i (
    .pclk(pclk), .rst_n(prst_n), .cam_d(cam_d), .cam_href(cam_href),
    .cam_vsync(cam_vsync), .cfg_href_low(cfg_href_low), .cfg_vsync_low(cfg_vsync_low),
    .cfg_order(cfg_order), .cfg_width(cfg_width), .cap_mode(cap_mode),
    .wr_en(wr_en), .wr_data(wr_data), .line_end(line_end), .line_sof(line_sof),
    .frame_start(frame_start), .frame_cnt(frame_cnt), .line_cnt(line_cnt),
    .line_err(line_err)
  );

  pixcap_linebuf #(.MAX_W(MAX_W)) lbuf_i (
    .clk(pclk), .rst_n(prst_n), .wr_en(wr_en), .wr_data(wr_data),
    .line_end(line_end), .line_sof(line_sof), .mirror(cfg_mirror),
    .frame_start(frame_start), .fifo_full(fifo_full), .push(push),
    .push_data(push_data), .ovf(ovf_err), .fill(lb_fill)
  );

  pixcap_afifo #(.DW(34), .AW(FIFO_AW)) fifo_i (
    .wclk(pclk), .wrst_n(prst_n), .push(push), .wdata(push_data), .full(fifo_full),
    .rclk(sys_clk), .rrst_n(srst_n), .pop(sys_ready), .rdata(pop_data),
    .empty(fifo_empty)
  );

  assign sys_valid = !fifo_empty;
  assign {sys_sof, sys_eol, sys_data} = pop_data;

  // R7
  fill_limit_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    CNT_W'(lb_fill) <= (cfg_width >> 1));

endmodule

// File: tb/pixcap_tb_top.sv
module pixcap_tb_top;
  localparam int PCLK_PERIOD = 14;
  localparam int SYS_PERIOD  = 6;

  logic pclk = 0, sys_clk = 0;
  logic prst_n = 0, srst_n = 0;
  logic [7:0] cam_d = 0;
  logic cam_href = 0, cam_vsync = 0;
  logic hlow = 0, vlow = 0, cfg_mirror = 0;
  logic [1:0] cfg_order = 0, cap_mode = 0;
  logic [13:0] cfg_width = 8;
  logic sys_ready = 1;
  logic sys_valid, sys_sof, sys_eol, line_err, ovf_err;
  logic [31:0] sys_data;
  logic [15:0] frame_cnt;
  logic [13:0] line_cnt;

  always #(PCLK_PERIOD/2) pclk = ~pclk;
  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

  pixcap_top dut_i (
    .pclk(pclk), .prst_n(prst_n), .cam_d(cam_d), .cam_href(cam_href), .cam_vsync(cam_vsync),
    .cfg_href_low(hlow), .cfg_vsync_low(vlow), .cfg_order(cfg_order), .cfg_mirror(cfg_mirror),
    .cfg_width(cfg_width), .cap_mode(cap_mode), .sys_clk(sys_clk), .srst_n(srst_n),
    .sys_ready(sys_ready), .sys_valid(sys_valid), .sys_data(sys_data), .sys_sof(sys_sof),
    .sys_eol(sys_eol), .frame_cnt(frame_cnt), .line_cnt(line_cnt), .line_err(line_err),
    .ovf_err(ovf_err)
  );

  int checks = 0, errors = 0;
  bit done = 0, bp_en = 0, ready_lvl = 1;
  logic [33:0] got[$], exp_q[$];

  // vector: ord[31:30] mirror[29] hlow[28] vlow[27] width[26:19] lines[18:15] bytes[14:7]
  localparam logic [31:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 8'd8,  4'd3, 8'd16,  7'd0},
    {2'd1, 1'b0, 1'b1, 1'b1, 8'd8,  4'd2, 8'd16,  7'd0},
    {2'd2, 1'b1, 1'b0, 1'b1, 8'd6,  4'd2, 8'd12,  7'd0},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'd10, 4'd3, 8'd20,  7'd0},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'd4,  4'd2, 8'd24,  7'd0},
    {2'd2, 1'b0, 1'b0, 1'b0, 8'd8,  4'd2, 8'd10,  7'd0},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'd4,  4'd1, 8'd9,   7'd0},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'd64, 4'd2, 8'd128, 7'd0}
  };

  always @(negedge sys_clk)
    if (sys_valid === 1'b1 && sys_ready === 1'b1) got.push_back({sys_sof, sys_eol, sys_data});

  initial begin : ready_drv
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    forever begin
      @(posedge sys_clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sys_ready = bp_en ? lfsr[0] : ready_lvl;
    end
  end

  function automatic logic [7:0] pix(int l, int k);
    return 8'(l * 29 + k * 7 + 3);
  endfunction

  // role: 0=Y0 1=Cb 2=Y1 3=Cr ; returns byte lane in the 4-byte group
  function automatic int lane(int ord, int role);
    case (ord)
      0: return role;
      1: return (role == 1) ? 3 : (role == 3) ? 1 : role;
      2: return (role == 0) ? 1 : (role == 1) ? 0 : (role == 2) ? 3 : 2;
      default: return (role == 0) ? 1 : (role == 1) ? 2 : (role == 2) ? 3 : 0;
    endcase
  endfunction

  task automatic build_exp(int ord, bit mir, int width, int lines, int nbytes);
    int nw;
    nw = (nbytes / 4 < width / 2) ? nbytes / 4 : width / 2;
    for (int l = 0; l < lines; l++)
      for (int j = 0; j < nw; j++) begin
        int p;
        logic [7:0] y0, cb, y1, cr;
        p  = mir ? nw - 1 - j : j;
        y0 = pix(l, 4 * p + lane(ord, 0));
        cb = pix(l, 4 * p + lane(ord, 1));
        y1 = pix(l, 4 * p + lane(ord, 2));
        cr = pix(l, 4 * p + lane(ord, 3));
        exp_q.push_back({(l == 0 && j == 0), (j == nw - 1),
                         mir ? {y1, cb, y0, cr} : {y0, cb, y1, cr}});
      end
  endtask

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cmp_words(string tag, int upto);
    int n;
    n = (upto < 0) ? exp_q.size() : upto;
    checks++;
    if (got.size() != n) begin
      errors++;
      $display("FAIL %s word count actual=%0d expected=%0d", tag, got.size(), n);
    end else
      for (int i = 0; i < n; i++)
        if (got[i] !== exp_q[i]) begin
          errors++;
          $display("FAIL %s word %0d actual=%0h expected=%0h", tag, i, got[i], exp_q[i]);
          break;
        end
  endtask

  task automatic do_reset();
    prst_n = 0; srst_n = 0;
    cam_href = hlow; cam_vsync = vlow;
    repeat (4) @(negedge pclk);
    prst_n = 1; srst_n = 1;
    repeat (4) @(negedge pclk);
  endtask

  task automatic send_frame(int lines, int nbytes, int stop_after);
    @(negedge pclk); cam_vsync = ~vlow;
    repeat (2) @(negedge pclk);
    cam_vsync = vlow;
    repeat (3) @(negedge pclk);
    for (int l = 0; l < lines; l++) begin
      for (int k = 0; k < nbytes; k++) begin
        cam_href = ~hlow;
        cam_d = pix(l, k);
        @(negedge pclk);
      end
      cam_href = hlow;
      if (l + 1 == stop_after) cap_mode = 2'd0;
      repeat (8) @(negedge pclk);
    end
    repeat (60) @(negedge pclk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge pclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R11 reset state
    chk(sys_valid === 1'b0, "R11 valid", sys_valid, 0);
    chk(frame_cnt === 0 && line_cnt === 0, "R11 counters", {frame_cnt, line_cnt}, 0);
    chk(line_err === 1'b0 && ovf_err === 1'b0, "R11 flags", {line_err, ovf_err}, 0);

    // Vector walk: R1 R2 R3 R4 R7 R8 R9 R12
    for (int v = 0; v < 8; v++) begin
      logic [31:0] e;
      int ord, w, ln, nb;
      e = VEC[v];
      ord = int'(e[31:30]); w = int'(e[26:19]); ln = int'(e[18:15]); nb = int'(e[14:7]);
      cfg_order = e[31:30]; cfg_mirror = e[29]; hlow = e[28]; vlow = e[27];
      cfg_width = 14'(w); cap_mode = 2'd1; bp_en = v[0];
      do_reset();
      got.delete(); exp_q.delete();
      build_exp(ord, e[29], w, ln, nb);
      send_frame(ln, nb, -1);
      cmp_words($sformatf("R1 R2 R3 R4 R7 R12 vec%0d", v), -1);
      chk(frame_cnt == 1, $sformatf("R9 frame_cnt vec%0d", v), frame_cnt, 1);
      chk(line_cnt == 14'(ln), $sformatf("R9 line_cnt vec%0d", v), line_cnt, ln);
      chk(line_err == ((nb % 2 == 1) || nb < 2 * w), $sformatf("R8 line_err vec%0d", v),
          line_err, (nb % 2 == 1) || nb < 2 * w);
      chk(ovf_err == 0, $sformatf("R12 no overflow vec%0d", v), ovf_err, 0);
    end
    bp_en = 0; ready_lvl = 1;

    // R5 stop mode captures nothing
    cfg_order = 0; cfg_mirror = 0; hlow = 0; vlow = 0; cfg_width = 8; cap_mode = 0;
    do_reset();
    got.delete(); exp_q.delete();
    send_frame(2, 16, -1);
    chk(got.size() == 0, "R5 stop words", got.size(), 0);
    chk(frame_cnt == 0, "R5 stop frame_cnt", frame_cnt, 0);

    // R6 single-shot: one frame of two, then re-arm
    cap_mode = 2;
    repeat (5) @(negedge pclk);
    got.delete(); exp_q.delete();
    build_exp(0, 0, 8, 2, 16);
    send_frame(2, 16, -1);
    send_frame(2, 16, -1);
    cmp_words("R6 single words", -1);
    chk(frame_cnt == 1, "R6 single frame_cnt", frame_cnt, 1);
    cap_mode = 0; repeat (5) @(negedge pclk);
    cap_mode = 2; repeat (5) @(negedge pclk);
    send_frame(2, 16, -1);
    chk(frame_cnt == 2, "R6 rearm frame_cnt", frame_cnt, 2);

    // R5 stop requested mid-frame keeps the frame whole
    cap_mode = 1;
    do_reset();
    got.delete(); exp_q.delete();
    build_exp(0, 0, 8, 3, 16);
    send_frame(3, 16, 1);
    send_frame(3, 16, -1);
    cmp_words("R5 mid-frame stop words", -1);
    chk(frame_cnt == 1, "R5 mid-frame frame_cnt", frame_cnt, 1);
    chk(line_cnt == 3, "R9 line_cnt kept", line_cnt, 3);

    // R10 overflow with a stalled consumer
    cap_mode = 1; ready_lvl = 0;
    do_reset();
    got.delete(); exp_q.delete();
    build_exp(0, 0, 8, 5, 16);
    send_frame(5, 16, -1);
    chk(ovf_err == 1, "R10 ovf flag", ovf_err, 1);
    ready_lvl = 1;
    repeat (60) @(negedge sys_clk);
    cmp_words("R10 kept words", 16);
    got.delete();
    send_frame(5, 16, -1);
    cmp_words("R10 recovery words", -1);
    chk(ovf_err == 1, "R10 ovf sticky", ovf_err, 1);
    chk(frame_cnt == 2, "R9 two frames", frame_cnt, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule